// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs single accesses on a parallel asynchronous memory bus. Each chip-select line owns a set of timing registers and an address window, written through a simple indexed configuration port. When a request is accepted, its address is matched against the windows. The matching chip select is chosen and a tick counter starts at zero. The bus strobes then switch on and off at the tick counts programmed for that chip select. Chip select and address-valid have separate release points for reads and writes. Write-enable is used only on writes, and output-enable only on reads.

A read samples the bus data at the programmed access tick. Every access ends after its programmed read or write length, and a one-cycle done pulse carries the captured data back. A request that falls in no window never reaches the bus; it is answered with a one-cycle error pulse. All strobes are active-high registered outputs, and one tick equals one clock cycle.

Top module: `strobe_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, every strobe, `rsp_done`, `rsp_err`, `rsp_rdata`, `bus_addr` and `bus_wdata` are low and `req_ready` is high.
- R2: Reset clears every timing field and every window base and size to zero. A window of size zero matches no address, so the first request after reset gets an error response.
- R3: Tick t of an access is shown in the t+1-th cycle after the acceptance edge. The selected chip-select bit is high on the ticks t with cs_on <= t < off, where off is cs_rd_off on reads and cs_wr_off on writes. All other chip-select bits stay low.
- R4: `bus_adv` is high on the ticks with adv_on <= t < off, where off is adv_rd_off on reads and adv_wr_off on writes.
- R5: `bus_we` is high only on write accesses, on the ticks with we_on <= t < we_off.
- R6: `bus_oe` is high only on read accesses, on the ticks with oe_on <= t < oe_off.
- R7: On a read, `rsp_rdata` takes the `bus_rdata` value present during tick `access`. Reads whose access tick lies past the end of the access, and all writes, return zero.
- R8: An access with length L (rd_len on reads, wr_len on writes) lasts max(L,1) ticks. `rsp_done` pulses high for exactly one cycle, in the cycle after the last tick.
- R9: `req_ready` is high exactly when no access is running, and a request is taken on a cycle with `req_valid` and `req_ready` both high. `bus_addr` and `bus_wdata` take the request address and the write data (zero for a read) from the acceptance of a matching request and hold them until the next one.
- R10: An accepted request that matches no window drives no strobe and starts no access. It pulses `rsp_err` in the cycle after acceptance, and `req_ready` stays high.
- R11: A chip select matches when base <= addr < base + size. If several windows match, the lowest-numbered chip select wins.
- R12: Timing values are latched when a request is accepted. A configuration write during an access affects only later accesses.
- R13: A configuration write (`cfg_we`) targets chip select `cfg_sel` and field `cfg_idx`: 0 cs_on, 1 cs_rd_off, 2 cs_wr_off, 3 adv_on, 4 adv_rd_off, 5 adv_wr_off, 6 we_on, 7 we_off, 8 oe_on, 9 oe_off, 10 access, 11 rd_len, 12 wr_len (each taken from `cfg_wdata[4:0]`), 13 window base and 14 window size (the full `cfg_wdata`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Chip select addressed by the write |
| cfg_idx | input | 4 | Field index of the write |
| cfg_wdata | input | ADDR_W | Configuration value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle pulse for an unmatched address |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_cs | output | NUM_CS | Chip-select strobes, active high |
| bus_adv | output | 1 | Address-valid strobe |
| bus_we | output | 1 | Write-enable strobe |
| bus_oe | output | 1 | Output-enable strobe |
| bus_addr | output | ADDR_W | Address driven to the memory |
| bus_wdata | output | DATA_W | Data driven to the memory |
| bus_rdata | input | DATA_W | Data returned by the memory |

## Verification
The bench aims at the tick edges. With on equal to off, a strobe must never rise; a window comparison off by one would give a one-tick pulse. Zero lengths must still produce one tick, and a counter that waited for length ticks from zero would hang or wrap. An access tick beyond the cycle length must leave the data at zero instead of sampling late. It also probes the last and first-outside addresses of a window, overlapping windows where a wrong priority would assert two chip selects or the wrong one, and a configuration write during an access, which would reshape a running cycle if the timing were not latched.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  localparam int TICK_W = 5;

  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    tick_t cs_on;
    tick_t cs_rd_off;
    tick_t cs_wr_off;
    tick_t adv_on;
    tick_t adv_rd_off;
    tick_t adv_wr_off;
    tick_t we_on;
    tick_t we_off;
    tick_t oe_on;
    tick_t oe_off;
    tick_t access;
    tick_t rd_len;
    tick_t wr_len;
  } timing_t;

  typedef enum logic [3:0] {
    F_CS_ON      = 4'd0,
    F_CS_RD_OFF  = 4'd1,
    F_CS_WR_OFF  = 4'd2,
    F_ADV_ON     = 4'd3,
    F_ADV_RD_OFF = 4'd4,
    F_ADV_WR_OFF = 4'd5,
    F_WE_ON      = 4'd6,
    F_WE_OFF     = 4'd7,
    F_OE_ON      = 4'd8,
    F_OE_OFF     = 4'd9,
    F_ACCESS     = 4'd10,
    F_RD_LEN     = 4'd11,
    F_WR_LEN     = 4'd12,
    F_BASE       = 4'd13,
    F_SIZE       = 4'd14
  } field_e;
endpackage

// File: rtl/strobe_seq_regs.sv
module strobe_seq_regs
  import strobe_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [3:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic [SEL_W-1:0]  hit_sel,
  output timing_t           hit_tm
);
  timing_t           tm_q   [NUM_CS];
  logic [ADDR_W-1:0] base_q [NUM_CS];
  logic [ADDR_W-1:0] size_q [NUM_CS];
  logic [NUM_CS-1:0] hit_v;
  tick_t             wv;

  assign wv = cfg_wdata[TICK_W-1:0];

  // R13: indexed field write; R2: everything clears on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CS; i++) begin
        tm_q[i]   <= '0;
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_idx)
        F_CS_ON:      tm_q[cfg_sel].cs_on      <= wv;
        F_CS_RD_OFF:  tm_q[cfg_sel].cs_rd_off  <= wv;
        F_CS_WR_OFF:  tm_q[cfg_sel].cs_wr_off  <= wv;
        F_ADV_ON:     tm_q[cfg_sel].adv_on     <= wv;
        F_ADV_RD_OFF: tm_q[cfg_sel].adv_rd_off <= wv;
        F_ADV_WR_OFF: tm_q[cfg_sel].adv_wr_off <= wv;
        F_WE_ON:      tm_q[cfg_sel].we_on      <= wv;
        F_WE_OFF:     tm_q[cfg_sel].we_off     <= wv;
        F_OE_ON:      tm_q[cfg_sel].oe_on      <= wv;
        F_OE_OFF:     tm_q[cfg_sel].oe_off     <= wv;
        F_ACCESS:     tm_q[cfg_sel].access     <= wv;
        F_RD_LEN:     tm_q[cfg_sel].rd_len     <= wv;
        F_WR_LEN:     tm_q[cfg_sel].wr_len     <= wv;
        F_BASE:       base_q[cfg_sel]          <= cfg_wdata;
        F_SIZE:       size_q[cfg_sel]          <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // R11: one window comparator per chip select
  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign hit_v[g] = (size_q[g] != '0) && (lookup_addr >= base_q[g]) &&
                      ((lookup_addr - base_q[g]) < size_q[g]);
  end

  // R11: lowest index wins on overlap
  always_comb begin
    hit_sel = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_v[i]) hit_sel = SEL_W'(i);
    end
  end

  assign hit    = |hit_v;
  assign hit_tm = tm_q[hit_sel];

  a_r2_no_hit_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);
endmodule

// File: rtl/strobe_seq_timer.sv
module strobe_seq_timer
  import strobe_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  input  logic [NUM_CS-1:0] start_sel,
  input  timing_t           start_tm,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic [NUM_CS-1:0] cs,
  output logic              adv,
  output logic              we,
  output logic              oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int CMP_W = TICK_W + 1;

  logic              busy_q, wr_q;
  tick_t             cnt_q;
  timing_t           tm_q;
  logic [NUM_CS-1:0] sel_q;

  logic              n_busy, n_wr, last, cap;
  tick_t             n_cnt, len;
  timing_t           n_tm;
  logic [NUM_CS-1:0] n_sel;

  function automatic logic in_win(tick_t t, tick_t on, tick_t off);
    return (t >= on) && (t < off);
  endfunction

  always_comb begin
    len    = wr_q ? tm_q.wr_len : tm_q.rd_len;
    // R8: last tick once t+1 reaches the length (a zero length still gives one tick)
    last   = busy_q && ((CMP_W'(cnt_q) + CMP_W'(1)) >= CMP_W'(len));
    cap    = busy_q && !wr_q && (cnt_q == tm_q.access);
    n_busy = start | (busy_q & ~last);
    n_cnt  = start ? '0 : (busy_q ? cnt_q + tick_t'(1) : cnt_q);
    n_wr   = start ? start_write : wr_q;
    n_tm   = start ? start_tm : tm_q;   // R12: snapshot at acceptance
    n_sel  = start ? start_sel : sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      tm_q   <= '0;
      sel_q  <= '0;
      cs     <= '0;
      adv    <= 1'b0;
      we     <= 1'b0;
      oe     <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      busy_q <= n_busy;
      wr_q   <= n_wr;
      cnt_q  <= n_cnt;
      tm_q   <= n_tm;
      sel_q  <= n_sel;
      // strobes registered from the next tick so each appears on its own tick
      cs  <= (n_busy && in_win(n_cnt, n_tm.cs_on,
                               n_wr ? n_tm.cs_wr_off : n_tm.cs_rd_off)) ? n_sel : '0;
      adv <= n_busy && in_win(n_cnt, n_tm.adv_on,
                              n_wr ? n_tm.adv_wr_off : n_tm.adv_rd_off);
      we  <= n_busy &&  n_wr && in_win(n_cnt, n_tm.we_on, n_tm.we_off);
      oe  <= n_busy && !n_wr && in_win(n_cnt, n_tm.oe_on, n_tm.oe_off);
      done <= last;
      if (start)    rdata <= '0;
      else if (cap) rdata <= bus_rdata;
    end
  end

  assign busy = busy_q;

  a_r5_we_write_only: assert property (@(posedge clk) disable iff (rst)
    we |-> wr_q);
  a_r6_oe_read_only: assert property (@(posedge clk) disable iff (rst)
    oe |-> !wr_q);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_after_access: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy_q && $past(busy_q)));
  a_r8_tick_in_range: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |-> (cnt_q < len));
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [3:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CS-1:0] bus_cs,
  output logic              bus_adv,
  output logic              bus_we,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic             hit, busy, accept, start;
  logic [SEL_W-1:0] hit_sel;
  timing_t          hit_tm;

  strobe_seq_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lookup_addr(req_addr),
    .hit(hit), .hit_sel(hit_sel), .hit_tm(hit_tm)
  );

  assign req_ready = !busy;                  // R9
  assign accept    = req_valid && req_ready;
  assign start     = accept && hit;

  strobe_seq_timer #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst(rst), .start(start), .start_write(req_write),
    .start_sel(NUM_CS'(1) << hit_sel), .start_tm(hit_tm),
    .bus_rdata(bus_rdata), .busy(busy), .cs(bus_cs), .adv(bus_adv),
    .we(bus_we), .oe(bus_oe), .done(rsp_done), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_err   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      rsp_err <= accept && !hit;             // R10
      if (start) begin
        bus_addr  <= req_addr;
        bus_wdata <= req_write ? req_wdata : '0;
      end
    end
  end

  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_cs));
  a_r10_miss_stays_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (req_ready && bus_cs == '0 && !bus_adv && !bus_we && !bus_oe));
endmodule

// File: tb/test_strobe_seq.sv
`timescale 1ns/1ps
module test_strobe_seq;
  localparam int NCS = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [3:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic          req_ready, rsp_done, rsp_err, bus_adv, bus_we, bus_oe;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [NCS-1:0] bus_cs;

  strobe_seq #(.NUM_CS(NCS), .ADDR_W(AW), .DATA_W(DW)) i_strobe_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_cs(bus_cs), .bus_adv(bus_adv), .bus_we(bus_we), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit cmp_en = 0;

  // ---------------- behavioural reference model ----------------
  int mt [NCS][15];
  int mbusy = 0, mcnt = 0, mwr = 0, msel = 0, mdone = 0, merr = 0;
  int mrdata = 0, maddr = 0, mwdata = 0;
  int snap [13];

  function automatic bit win(int t, int on, int off);
    return (t >= on) && (t < off);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mt[i, j]) mt[i][j] = 0;
      foreach (snap[k]) snap[k] = 0;
      mbusy = 0; mcnt = 0; mwr = 0; msel = 0; mdone = 0; merr = 0;
      mrdata = 0; maddr = 0; mwdata = 0;
    end else begin
      int was_busy, len, found;
      was_busy = mbusy;
      mdone = 0;
      merr  = 0;
      if (mbusy != 0) begin
        if (mwr == 0 && mcnt == snap[10]) mrdata = int'(bus_rdata);
        len = (mwr != 0) ? snap[12] : snap[11];
        if (len < 1) len = 1;
        if (mcnt + 1 >= len) begin mbusy = 0; mdone = 1; end
        else mcnt++;
      end
      if (req_valid && was_busy == 0) begin
        found = -1;
        for (int c = NCS - 1; c >= 0; c--)
          if (mt[c][14] != 0 && int'(req_addr) >= mt[c][13] &&
              int'(req_addr) < mt[c][13] + mt[c][14]) found = c;
        if (found >= 0) begin
          mbusy = 1; mcnt = 0; mwr = int'(req_write); msel = found;
          for (int k = 0; k < 13; k++) snap[k] = mt[found][k];
          maddr = int'(req_addr);
          mwdata = req_write ? int'(req_wdata) : 0;
          mrdata = 0;
        end else merr = 1;
      end
      if (cfg_we) mt[cfg_sel][cfg_idx] = (cfg_idx >= 13) ? int'(cfg_wdata) : int'(cfg_wdata[4:0]);
    end
  end

  task automatic chk(string rq, string nm, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, nm, act, exp);
    end
  endtask

  // lock-step comparison on every falling edge
  always @(negedge clk) begin
    cyc++;
    bus_rdata <= DW'(cyc * 37 + 5);
    if (cmp_en) begin
      int ecs;
      ecs = (mbusy != 0 && win(mcnt, snap[0], (mwr != 0) ? snap[2] : snap[1])) ? (1 << msel) : 0;
      chk(rst ? "R1" : "R3 R13", "bus_cs", bus_cs, ecs);
      chk(rst ? "R1" : "R4", "bus_adv", bus_adv,
          (mbusy != 0 && win(mcnt, snap[3], (mwr != 0) ? snap[5] : snap[4])) ? 1 : 0);
      chk(rst ? "R1" : "R5", "bus_we", bus_we,
          (mbusy != 0 && mwr != 0 && win(mcnt, snap[6], snap[7])) ? 1 : 0);
      chk(rst ? "R1" : "R6", "bus_oe", bus_oe,
          (mbusy != 0 && mwr == 0 && win(mcnt, snap[8], snap[9])) ? 1 : 0);
      chk(rst ? "R1" : "R7", "rsp_rdata", rsp_rdata, mrdata);
      chk(rst ? "R1" : "R8", "rsp_done", rsp_done, mdone);
      chk(rst ? "R1" : "R10", "rsp_err", rsp_err, merr);
      chk(rst ? "R1" : "R9", "req_ready", req_ready, (mbusy == 0) ? 1 : 0);
      chk(rst ? "R1" : "R9", "bus_addr", bus_addr, maddr);
      chk(rst ? "R1" : "R9", "bus_wdata", bus_wdata, mwdata);
    end
  end

  // observation flags for directed checks
  logic [NCS-1:0] cs_seen = '0;
  bit oe_seen = 0, err_seen = 0;
  always @(negedge clk) begin
    cs_seen  |= bus_cs;
    oe_seen  |= bus_oe;
    err_seen |= rsp_err;
  end

  task automatic cfg(int c, int idx, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(c); cfg_idx = 4'(idx); cfg_wdata = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_timing(int c, int v [13]);
    for (int k = 0; k < 13; k++) cfg(c, k, v[k]);
  endtask

  task automatic do_req(bit wr, int addr, int wd);
    @(negedge clk);
    cs_seen = '0; oe_seen = 0; err_seen = 0;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_wdata = DW'(wd);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int t0 [13] = '{1, 8, 6, 0, 2, 3, 2, 5, 3, 9, 7, 10, 7};
    int t1 [13] = '{0, 4, 5, 1, 3, 2, 1, 4, 2, 5, 20, 5, 6};
    int t2 [13] = '{2, 2, 3, 0, 1, 1, 3, 3, 0, 2, 1, 3, 4};
    repeat (3) @(posedge clk);
    @(negedge clk); cmp_en = 1;               // R1: compared while in reset
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);

    // R2: nothing programmed, so every address misses
    do_req(0, 'h0100, 0); wait_idle();
    chk("R2", "err on unprogrammed", err_seen, 1);

    cfg(0, 13, 'h0100); cfg(0, 14, 'h0100); cfg_timing(0, t0);
    cfg(1, 13, 'h1000); cfg(1, 14, 'h0040); cfg_timing(1, t1);
    cfg(2, 13, 'h1020); cfg(2, 14, 'h0100); cfg_timing(2, t2);
    cfg(3, 13, 'h4000); cfg(3, 14, 'h0001);   // all-zero timing on CS3

    do_req(0, 'h0150, 0);      wait_idle();   // R6 R7 read on CS0
    do_req(1, 'h0150, 'hBEEF); wait_idle();   // R5 write on CS0
    do_req(0, 'h01FF, 0);      wait_idle();   // R11 last address in window
    chk("R11", "cs at window top", cs_seen, 4'b0001);
    do_req(0, 'h0200, 0);      wait_idle();   // R11 first address outside
    chk("R10", "err past window", err_seen, 1);
    chk("R10", "no cs on miss", cs_seen, 0);
    do_req(0, 'h1030, 0);      wait_idle();   // R11 overlap: CS1 wins
    chk("R11", "overlap lowest index", cs_seen, 4'b0010);
    do_req(1, 'h1050, 'h1234); wait_idle();   // CS2 only
    chk("R11", "upper window", cs_seen, 4'b0100);
    do_req(0, 'h1000, 0);      wait_idle();   // R7 access past length on CS1
    chk("R7", "late access reads zero", rsp_rdata, 0);
    do_req(0, 'h4000, 0);      wait_idle();   // R8 zero length: one tick, no strobes
    chk("R8", "zero timing no cs", cs_seen, 0);

    // R12: change oe_off of CS0 while an access is running
    @(negedge clk);
    cs_seen = '0; oe_seen = 0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 'h0120;
    @(negedge clk); req_valid = 1'b0;
    cfg(0, 9, 0);
    wait_idle();
    chk("R12", "running access keeps oe", oe_seen, 1);
    do_req(0, 'h0120, 0); wait_idle();
    chk("R12", "later access uses new oe", oe_seen, 0);

    // R9: back-to-back requests with valid held high
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 'h0110; req_wdata = 'h00AA;
    @(negedge clk); req_addr = 'h1010; req_wdata = 'h0055; req_write = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    wait_idle();

    // randomized timings and requests, checked in lock step
    for (int n = 0; n < 60; n++) begin
      int c, v [13], a;
      c = $urandom_range(0, 3);
      for (int k = 0; k < 13; k++) v[k] = $urandom_range(0, 31);
      cfg_timing(c, v);
      case ($urandom_range(0, 4))
        0: a = 'h0100 + $urandom_range(0, 'hFF);
        1: a = 'h1000 + $urandom_range(0, 'h3F);
        2: a = 'h1020 + $urandom_range(0, 'hFF);
        3: a = 'h4000;
        default: a = $urandom_range(0, 'hFFFF);
      endcase
      do_req(1'($urandom_range(0, 1)), a, $urandom_range(0, 'hFFFF));
      wait_idle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R9 watchdog actual=hung expected=idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule